// File: doc/BRIEF.md
# Tower-Field Byte Multiplier

This block multiplies two bytes as elements of GF(2^8), where GF(2^8) is built as a degree-two extension of GF(2^4). Each byte holds two 4-bit coefficients over the subfield. The upper nibble `h` and the lower nibble `l` together stand for the element `h·x + l`. The product of the two polynomials is reduced by the outer quadratic `x^2 + x + 9`. Every nibble product inside is reduced by `x^4 + x + 1`.

The arithmetic is purely combinational. One subfield multiplier is built for each pair of nibbles. Each one forms the bitwise partial products, folds them into seven diagonal sums and reduces those to four bits. The parameter `REG_OUT` selects whether the product passes through one output register. With the default `REG_OUT = 1`, the product appears one clock after the operands are sampled. With `REG_OUT = 0`, the output is combinational and the clock and reset are not used.

Top module: `gf256_tower_mul`

## Requirements
- R1: With the operands split as a = {ah, al} and b = {bh, bl} (ah, bh in bits 7:4), the result is {ch, cl} with ch = ah·bh ⊕ ah·bl ⊕ al·bh and cl = al·bl ⊕ 9·ah·bh, all taken in GF(2^4).
- R2: Nibble products reduce by x^4 + x + 1. For example, 0x02 · 0x08 gives 0x03, and 0x04 · 0x04 gives 0x03.
- R3: The outer field reduces by x^2 + x + 9. For example, 0x10 · 0x10 gives 0x19, and 0x10 · 0x01 gives 0x10.
- R4: A zero operand on either side gives a zero product.
- R5: The value 0x01 is the identity, so 0x01 · b = b and a · 0x01 = a.
- R6: The product is commutative: a · b equals b · a.
- R7: With REG_OUT = 1, the product of operands present at a rising clock edge appears at `prod` after that edge. While `rst_n` is low, `prod` is 0x00.
- R8: All 65536 operand pairs produce the tower-field product described in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 8 | First operand, {high nibble, low nibble} |
| op_b | input | 8 | Second operand, same layout |
| prod | output | 8 | Tower-field product |

## Verification
The hardest case to reach is a product in which both the subfield reduction and the outer reduction by the constant 9 fire together. The directed cases isolate each reduction separately: a low-nibble-only case drives the x^4 fold, and 0x10 squared drives the x^2 fold. An exhaustive sweep of every operand pair then covers all combinations of high-degree terms. Each result is compared with a shift-and-add model of the field kept in the bench.

// File: rtl/gf256_tower_mul.sv
module gf256_tower_mul #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] op_a,
  input  logic [7:0] op_b,
  output logic [7:0] prod
);

  function automatic logic [3:0] nib_mul(input logic [3:0] a, input logic [3:0] b);
    logic [6:0] s;
    s = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        s[i+j] = s[i+j] ^ (a[i] & b[j]);
    return {s[3] ^ s[6], s[2] ^ s[5] ^ s[6], s[1] ^ s[4] ^ s[5], s[0] ^ s[4]};
  endfunction

  function automatic logic [3:0] nib_times9(input logic [3:0] a);
    return {a[0], a[3], a[2], a[0] ^ a[1]};
  endfunction

  logic [3:0] hh, hl, lh, ll, ch, cl;
  logic [7:0] comb_prod;

  assign hh = nib_mul(op_a[7:4], op_b[7:4]);
  assign hl = nib_mul(op_a[7:4], op_b[3:0]);
  assign lh = nib_mul(op_a[3:0], op_b[7:4]);
  assign ll = nib_mul(op_a[3:0], op_b[3:0]);

  assign ch = hh ^ hl ^ lh;
  assign cl = ll ^ nib_times9(hh);
  assign comb_prod = {ch, cl};

  generate
    if (REG_OUT) begin : g_reg
      logic [7:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= comb_prod;
      end
      assign prod = prod_q;
    end else begin : g_comb
      assign prod = comb_prod;
    end
  endgenerate

endmodule

module gf256_tower_mul_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] op_a,
  input logic [7:0] op_b,
  input logic [7:0] prod
);

  generate
    if (REG_OUT) begin : g_seq
      // R4
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_a) == 8'h00 || $past(op_b) == 8'h00)) |-> prod == 8'h00);
      // R5
      identity_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_a) == 8'h01) |-> prod == $past(op_b));
      // R5
      identity_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_b) == 8'h01) |-> prod == $past(op_a));
      // R3
      outer_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_a) == 8'h10 && $past(op_b) == 8'h10) |-> prod == 8'h19);
      // R2
      sub_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_a) == 8'h02 && $past(op_b) == 8'h08) |-> prod == 8'h03);
      // R7
      reset_clear_chk: assert property (@(posedge clk) !rst_n |-> prod == 8'h00);
    end else begin : g_comb
      // R4
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == 8'h00 || op_b == 8'h00) |-> prod == 8'h00);
      // R5
      identity_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == 8'h01) |-> prod == op_b);
      // R5
      identity_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_b == 8'h01) |-> prod == op_a);
      // R3
      outer_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == 8'h10 && op_b == 8'h10) |-> prod == 8'h19);
    end
  endgenerate

endmodule

bind gf256_tower_mul gf256_tower_mul_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/gf256_tower_mul_tb.sv
module gf256_tower_mul_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = 8'h00;
  logic [7:0] op_b = 8'h00;
  logic [7:0] prod;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  gf256_tower_mul #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod)
  );

  function automatic logic [3:0] ref_nib(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] r, sh;
    r = '0;
    sh = a;
    for (int k = 0; k < 4; k++) begin
      if (b[k]) r = r ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'b0011 : 4'b0000);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] t2, t1, t0;
    t2 = ref_nib(a[7:4], b[7:4]);
    t1 = ref_nib(a[7:4], b[3:0]) ^ ref_nib(a[3:0], b[7:4]);
    t0 = ref_nib(a[3:0], b[3:0]);
    return {t1 ^ t2, t0 ^ ref_nib(4'h9, t2)};
  endfunction

  task automatic compare(input string req, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, output logic [7:0] got);
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
    got = prod;
  endtask

  task automatic t_reset;
    logic [7:0] got;
    op_a = 8'h53;
    op_b = 8'hCA;
    repeat (3) @(negedge clk);
    compare("R7 reset", op_a, op_b, prod, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R7 latency", op_a, op_b, prod, ref_mul(8'h53, 8'hCA));
    apply(8'h00, 8'h00, got);
  endtask

  task automatic t_latency;
    @(negedge clk);
    op_a = 8'h37;
    op_b = 8'hE1;
    @(posedge clk);
    #2;
    op_a = 8'h00;
    @(negedge clk);
    compare("R7 held", 8'h37, 8'hE1, prod, ref_mul(8'h37, 8'hE1));
  endtask

  task automatic t_zero;
    logic [7:0] got;
    for (int v = 0; v < 256; v += 17) begin
      apply(8'h00, v[7:0], got);
      compare("R4", 8'h00, v[7:0], got, 8'h00);
      apply(v[7:0], 8'h00, got);
      compare("R4", v[7:0], 8'h00, got, 8'h00);
    end
  endtask

  task automatic t_identity;
    logic [7:0] got;
    for (int v = 1; v < 256; v += 23) begin
      apply(8'h01, v[7:0], got);
      compare("R5", 8'h01, v[7:0], got, v[7:0]);
      apply(v[7:0], 8'h01, got);
      compare("R5", v[7:0], 8'h01, got, v[7:0]);
    end
  endtask

  task automatic t_subfield;
    logic [7:0] got;
    apply(8'h02, 8'h08, got);
    compare("R2", 8'h02, 8'h08, got, 8'h03);
    apply(8'h04, 8'h04, got);
    compare("R2", 8'h04, 8'h04, got, 8'h03);
    apply(8'h0F, 8'h0F, got);
    compare("R2", 8'h0F, 8'h0F, got, 8'h0A);
  endtask

  task automatic t_outer;
    logic [7:0] got;
    apply(8'h10, 8'h10, got);
    compare("R3", 8'h10, 8'h10, got, 8'h19);
    apply(8'h10, 8'h01, got);
    compare("R3", 8'h10, 8'h01, got, 8'h10);
    apply(8'h20, 8'h10, got);
    compare("R3", 8'h20, 8'h10, got, 8'h21);
  endtask

  task automatic t_formula;
    logic [7:0] got;
    apply(8'hA7, 8'h3C, got);
    compare("R1", 8'hA7, 8'h3C, got, ref_mul(8'hA7, 8'h3C));
    apply(8'hFF, 8'hFF, got);
    compare("R1", 8'hFF, 8'hFF, got, ref_mul(8'hFF, 8'hFF));
  endtask

  task automatic t_commute;
    logic [7:0] g1, g2;
    for (int v = 3; v < 256; v += 29) begin
      apply(v[7:0], 8'hB5 ^ v[7:0], g1);
      apply(8'hB5 ^ v[7:0], v[7:0], g2);
      compare("R6", v[7:0], 8'hB5 ^ v[7:0], g2, g1);
    end
  endtask

  task automatic t_exhaustive;
    logic [7:0] got;
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++) begin
        apply(i[7:0], j[7:0], got);
        compare("R8", i[7:0], j[7:0], got, ref_mul(i[7:0], j[7:0]));
      end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_zero();
    t_identity();
    t_subfield();
    t_outer();
    t_formula();
    t_commute();
    t_exhaustive();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #3_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule